// File: doc/BRIEF.md
# Reference Clock Loss-of-Lock Monitor

This block watches a reference clock that arrives from outside the chip. It judges that clock against a stable local clock and produces a loss-of-lock flag. The flag is high in two cases. The first is that the reference has stopped toggling. The second is that its rate has left a programmed window around the nominal value. A window of plus or minus 2000 ppm is obtained by choosing the bounds to match. When the reference is healthy the flag is low, and this is the normal operating state.

The monitor counts reference edges in the reference domain on a Gray-coded counter. The count is carried into the local domain through a synchronizer and converted back to binary. The block then takes the difference in the count over a fixed window of local cycles. A separate timeout declares the reference missing when no count change has been seen for a programmable number of local cycles. Lock is granted only after a programmable run of consecutive good windows. It is withdrawn at once on any bad window or on a missing reference.

Downstream clock outputs that follow the reference run freely through a loss event by default. An option holds off, per output, only those outputs that are marked as following the reference. There is no data stream at this boundary, so every pin is a plain control or status level.

Top module: `lol_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, `lol` is 1. `out_en` then equals the bitwise inverse of `cfg_sync_mask` when `cfg_gate_on_loss` is 1.
- R2: One measurement is taken every `WIN_CYCLES` local cycles. It is the number of reference rising edges that fall inside that window, accurate to within one edge. A measurement within the inclusive range [`cfg_lo`, `cfg_hi`] counts as good.
- R3: A measurement below `cfg_lo` or above `cfg_hi` sets `lol` to 1 on the cycle after that window closes.
- R4: If no reference edge is observed for `cfg_timeout` local cycles, `lol` goes to 1 within a few cycles, whatever the window result. It does not rise before that timeout has run out.
- R5: `lol` returns to 0 only after `cfg_lock_cnt` consecutive good measurements taken while the reference is present. A bad measurement or a missing reference restarts the run.
- R6: `lol` changes only on the cycle after a window closes or after a missing reference is declared. While the reference stays in range, it remains 0 on every cycle.
- R7: `out_en[i]` is 0 exactly when `lol`, `cfg_gate_on_loss` and `cfg_sync_mask[i]` are all 1. Otherwise it is 1, so unmarked outputs and all outputs with the option off keep running.
- R8: The edge count crosses into the local domain as a Gray code. Successive synchronized values differ in at most one bit for any reference slower than the local clock. This holds up to the fastest rate, where one reference period is just above one local period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local stable timebase |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ref_clk | input | 1 | Monitored reference clock |
| cfg_lo | input | CNT_W | Smallest acceptable edge count per window |
| cfg_hi | input | CNT_W | Largest acceptable edge count per window |
| cfg_timeout | input | TMO_W | Local cycles without a reference edge before the reference counts as missing |
| cfg_lock_cnt | input | QUAL_W | Consecutive good windows needed to declare lock |
| cfg_sync_mask | input | NOUT | 1 marks an output as following the reference |
| cfg_gate_on_loss | input | 1 | 1 holds off marked outputs while `lol` is high |
| lol | output | 1 | Loss-of-lock flag, 0 when locked |
| out_en | output | NOUT | Per-output run permission, 1 lets the output run |

## Verification
The hardest condition to reach from the ports is a stopped reference that no window comparison would ever flag. Any window that contains the stop already reads a low count and raises the flag by itself. The bench therefore opens the bounds to the full count range before it halts the reference clock. Only the timeout path can then raise the flag, and both the earliest and the latest allowed cycle are checked. The window comparison is covered by a sweep of reference periods from 6 to 16 ns. At each period the bounds are set from the exact edge count expected per window: once straddling it, once entirely above it and once entirely below it.

// File: rtl/lol_pkg.sv
package lol_pkg;
  typedef enum logic [1:0] {
    QS_UNLOCKED = 2'd0,
    QS_QUALIFY  = 2'd1,
    QS_LOCKED   = 2'd2
  } qual_state_t;

  typedef struct packed {
    logic done;
    logic in_range;
  } meas_t;
endpackage

// File: rtl/lol_ref_counter.sv
module lol_ref_counter #(
  parameter int CNT_W = 16
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_q
);
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  assign bin_nx = bin_q + 1'b1;

  // binary and Gray copies advance together; only the Gray copy leaves this domain
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/lol_gray_sync.sv
module lol_gray_sync #(
  parameter int CNT_W       = 16,
  parameter int TMO_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_async,
  input  logic [TMO_W-1:0] cfg_timeout,
  output logic [CNT_W-1:0] ref_count,
  output logic             ref_missing
);
  logic [SYNC_STAGES-1:0][CNT_W-1:0] sync_q;
  logic [CNT_W-1:0] g_now;
  logic [CNT_W-1:0] g_prev;
  logic [CNT_W-1:0] bin_c;
  logic [TMO_W-1:0] idle_q;

  assign g_now = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      g_prev <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], gray_async};
      g_prev <= g_now;
    end
  end

  // Gray to binary, most significant bit first
  always_comb begin
    bin_c[CNT_W-1] = g_now[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      bin_c[i] = bin_c[i+1] ^ g_now[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_count <= '0;
    end else begin
      ref_count <= bin_c;
    end
  end

  // idle timer: restarts on any observed count change, saturates at all ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (g_now != g_prev) begin
      idle_q <= '0;
    end else if (idle_q != '1) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign ref_missing = (idle_q >= cfg_timeout);

  AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(g_now ^ g_prev) <= 1); // R8
endmodule

// File: rtl/lol_freq_meter.sv
module lol_freq_meter
  import lol_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int WIN_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ref_count,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic [CNT_W-1:0] cfg_hi,
  output meas_t            meas
);
  localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] delta;
  logic             win_end;

  assign win_end = (win_q == WIN_LAST);
  assign delta   = ref_count - base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_end) begin
      win_q <= '0;
    end else begin
      win_q <= win_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q        <= '0;
      meas.done     <= 1'b0;
      meas.in_range <= 1'b0;
    end else begin
      meas.done <= win_end;
      if (win_end) begin
        base_q        <= ref_count;
        meas.in_range <= (delta >= cfg_lo) && (delta <= cfg_hi);
      end
    end
  end

  AST_WINDOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    meas.done |=> !meas.done); // R2
endmodule

// File: rtl/lol_qualifier.sv
module lol_qualifier
  import lol_pkg::*;
#(
  parameter int QUAL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  meas_t             meas,
  input  logic              ref_missing,
  input  logic [QUAL_W-1:0] cfg_lock_cnt,
  output logic              lol
);
  qual_state_t       state_q, state_nx;
  logic [QUAL_W-1:0] run_q, run_nx;
  logic [QUAL_W:0]   run_inc;

  assign run_inc = {1'b0, run_q} + 1'b1;

  always_comb begin
    state_nx = state_q;
    run_nx   = run_q;
    if (ref_missing) begin
      state_nx = QS_UNLOCKED;
      run_nx   = '0;
    end else if (meas.done) begin
      if (!meas.in_range) begin
        state_nx = QS_UNLOCKED;
        run_nx   = '0;
      end else if (state_q != QS_LOCKED) begin
        if (run_inc >= {1'b0, cfg_lock_cnt}) begin
          state_nx = QS_LOCKED;
          run_nx   = '0;
        end else begin
          state_nx = QS_QUALIFY;
          run_nx   = run_inc[QUAL_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= QS_UNLOCKED;
      run_q   <= '0;
      lol     <= 1'b1;
    end else begin
      state_q <= state_nx;
      run_q   <= run_nx;
      lol     <= (state_nx != QS_LOCKED);
    end
  end

  AST_BAD_WINDOW_LOL: assert property (@(posedge clk) disable iff (!rst_n)
    (meas.done && !meas.in_range) |=> lol); // R3
  AST_MISSING_LOL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_missing |=> lol); // R4
  AST_LOCK_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol) |-> $past(meas.done && meas.in_range && !ref_missing)); // R5
  AST_LOL_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (lol != $past(lol)) |-> $past(meas.done || ref_missing)); // R6
endmodule

// File: rtl/lol_monitor.sv
module lol_monitor
  import lol_pkg::*;
#(
  parameter int NOUT        = 4,
  parameter int CNT_W       = 16,
  parameter int TMO_W       = 12,
  parameter int QUAL_W      = 6,
  parameter int WIN_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic [CNT_W-1:0]  cfg_lo,
  input  logic [CNT_W-1:0]  cfg_hi,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [QUAL_W-1:0] cfg_lock_cnt,
  input  logic [NOUT-1:0]   cfg_sync_mask,
  input  logic              cfg_gate_on_loss,
  output logic              lol,
  output logic [NOUT-1:0]   out_en
);
  logic [CNT_W-1:0] ref_gray;
  logic [CNT_W-1:0] ref_count;
  logic             ref_missing;
  meas_t            meas;

  lol_ref_counter #(.CNT_W(CNT_W)) u_ref_counter (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .gray_q  (ref_gray)
  );

  lol_gray_sync #(
    .CNT_W       (CNT_W),
    .TMO_W       (TMO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_gray_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .gray_async  (ref_gray),
    .cfg_timeout (cfg_timeout),
    .ref_count   (ref_count),
    .ref_missing (ref_missing)
  );

  lol_freq_meter #(
    .CNT_W      (CNT_W),
    .WIN_CYCLES (WIN_CYCLES)
  ) u_freq_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_count (ref_count),
    .cfg_lo    (cfg_lo),
    .cfg_hi    (cfg_hi),
    .meas      (meas)
  );

  lol_qualifier #(.QUAL_W(QUAL_W)) u_qualifier (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas         (meas),
    .ref_missing  (ref_missing),
    .cfg_lock_cnt (cfg_lock_cnt),
    .lol          (lol)
  );

  for (genvar gi = 0; gi < NOUT; gi++) begin : g_out_gate
    assign out_en[gi] = ~(lol & cfg_gate_on_loss & cfg_sync_mask[gi]);
  end

  AST_LOCKED_ALL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !lol |-> (&out_en)); // R7
endmodule

// File: tb/lol_monitor_bench.sv
`timescale 1ns/1ps
module lol_monitor_bench;
  localparam int NOUT  = 4;
  localparam int CNT_W = 16;
  localparam int TMO_W = 12;
  localparam int QW    = 6;
  localparam int WIN   = 64;
  localparam int WIN_NS = WIN * 5;
  localparam int LOCKN = 4;
  localparam int TMO   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic [CNT_W-1:0] cfg_lo, cfg_hi;
  logic [TMO_W-1:0] cfg_timeout;
  logic [QW-1:0] cfg_lock_cnt;
  logic [NOUT-1:0] cfg_sync_mask;
  logic cfg_gate_on_loss;
  logic lol;
  logic [NOUT-1:0] out_en;

  real ref_half = 5.0;
  bit  ref_run = 1'b1;
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;
  always begin
    #(ref_half);
    if (ref_run) ref_clk = ~ref_clk;
  end

  lol_monitor #(
    .NOUT(NOUT), .CNT_W(CNT_W), .TMO_W(TMO_W), .QUAL_W(QW),
    .WIN_CYCLES(WIN), .SYNC_STAGES(2)
  ) u_lol_monitor (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_timeout(cfg_timeout),
    .cfg_lock_cnt(cfg_lock_cnt), .cfg_sync_mask(cfg_sync_mask),
    .cfg_gate_on_loss(cfg_gate_on_loss), .lol(lol), .out_en(out_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ones;
    cfg_lo = 16'd30; cfg_hi = 16'd34;
    cfg_timeout = TMO_W'(TMO);
    cfg_lock_cnt = QW'(LOCKN);
    cfg_sync_mask = 4'b0101;
    cfg_gate_on_loss = 1'b1;
    cyc(5);
    chk(lol == 1'b1, "R1 lol in reset", int'(lol), 1);
    rst_n = 1'b1;
    cyc(1);
    chk(lol == 1'b1, "R1 lol after reset", int'(lol), 1);
    chk(out_en == 4'b1010, "R1 out_en after reset", int'(out_en), 10);

    // period sweep: bounds from the arithmetic edge count per window
    for (int p = 6; p <= 16; p++) begin
      int fl, ce;
      fl = WIN_NS / p;
      ce = (WIN_NS % p == 0) ? fl : fl + 1;
      ref_half = p / 2.0;
      // straddling bounds: must lock (R2; fastest period also covers R8)
      cfg_lo = CNT_W'(fl - 1); cfg_hi = CNT_W'(ce + 1);
      cyc(8 * WIN);
      chk(lol == 1'b0, (p == 6) ? "R8 lock at fastest ref" : "R2 lock in range",
          int'(lol), 0);
      // bounds above the count: too slow
      cfg_lo = CNT_W'(ce + 2); cfg_hi = CNT_W'(ce + 6);
      cyc(3 * WIN);
      chk(lol == 1'b1, "R3 count below lower bound", int'(lol), 1);
      // bounds below the count: too fast
      cfg_lo = '0; cfg_hi = CNT_W'(fl - 2);
      cyc(3 * WIN);
      chk(lol == 1'b1, "R3 count above upper bound", int'(lol), 1);
    end

    // hysteresis: lock takes LOCKN good windows
    ref_half = 5.0;
    cfg_lo = '0; cfg_hi = 16'd20;
    cyc(3 * WIN);
    chk(lol == 1'b1, "R5 bad before qualify", int'(lol), 1);
    cfg_lo = 16'd30; cfg_hi = 16'd34;
    cyc(120);
    chk(lol == 1'b1, "R5 still unlocked after two windows", int'(lol), 1);
    cyc(6 * WIN - 120);
    chk(lol == 1'b0, "R5 locked after run", int'(lol), 0);

    // no glitch while in range
    ones = 0;
    for (int i = 0; i < 5 * WIN; i++) begin
      cyc(1);
      if (lol) ones++;
    end
    chk(ones == 0, "R6 lol stays low while in range", ones, 0);

    // gating while locked
    for (int m = 0; m < 16; m++) begin
      for (int g = 0; g < 2; g++) begin
        cfg_sync_mask = 4'(m);
        cfg_gate_on_loss = g[0];
        #1;
        chk(out_en == 4'hF, "R7 locked all run", int'(out_en), 15);
      end
    end

    // missing reference with bounds fully open
    cfg_lo = '0; cfg_hi = '1;
    cyc(8 * WIN);
    chk(lol == 1'b0, "R4 locked with open bounds", int'(lol), 0);
    ref_run = 1'b0;
    cyc(10);
    chk(lol == 1'b0, "R4 not before timeout", int'(lol), 0);
    cyc(20);
    chk(lol == 1'b1, "R4 missing declared", int'(lol), 1);

    // gating while unlocked
    for (int m = 0; m < 16; m++) begin
      for (int g = 0; g < 2; g++) begin
        logic [3:0] exp;
        cfg_sync_mask = 4'(m);
        cfg_gate_on_loss = g[0];
        exp = g[0] ? ~4'(m) : 4'hF;
        #1;
        chk(out_en == exp, "R7 gating on loss", int'(out_en), int'(exp));
      end
    end

    cyc(8 * WIN);
    chk(lol == 1'b1, "R5 no lock while missing", int'(lol), 1);
    ref_run = 1'b1;
    cyc(8 * WIN);
    chk(lol == 1'b0, "R5 relock after return", int'(lol), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule